// File: doc/BRIEF.md
# Flash Control Register Unlock Unit

This unit is the register-level front end of an embedded flash array. Software reaches it through a plain 32-bit register port with a 5-bit byte offset. The unit keeps the command register shut until two fixed 32-bit keys arrive in order. After that, it accepts program, sector-erase and whole-array-erase commands. It reports progress through a busy flag and through sticky error flags that software clears by writing 1.

The array itself is not modelled. Each accepted operation keeps busy high for a programmable number of clock cycles. Two side inputs let a test environment inject a write-protection fault or an operation fault. Programming is started by a write on a separate flash-write port, which carries only the byte offset within a doubleword and the access width.

Top module: `flashctl_guard`

## Requirements
- R1: After reset, the control word (offset 0x10) reads 0x80000000, the status word (offset 0x0C) reads 0, and the duration word (offset 0x00, bits 15:0) reads 8.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key word (offset 0x04) clears the lock bit (bit 31 of control). After the first key alone, the lock bit still reads 1.
- R3: Any of the following sets a hard lock: a first key other than 0x45670123, a second key other than 0xCDEF89AB, or any key write while the unit is unlocked. Under a hard lock the lock bit reads 1 and no later key sequence unlocks the unit until reset.
- R4: While the unit is locked, control writes change nothing and start no operation.
- R5: A control write with bit 31 set, made while unlocked, relocks the unit at once, even while busy. The other bits of that write are discarded, and the full key sequence is needed again.
- R6: A control write with start (bit 16) set and exactly one erase bit set starts an erase. The erase bits are sector erase (bit 1), array erase (bit 2) and second-bank erase (bit 15); program enable (bit 0) must be clear. Busy (status bit 16) is then high for exactly max(duration, 1) cycles. The sector number is held in bits 6:3 and reads back.
- R7: Start with no erase bit, with more than one erase bit, or together with program enable sets the sequence flag (status bit 7) and leaves busy low.
- R8: While busy, control writes without bit 31 are ignored.
- R9: With program enable set, a flash-port write of width code w (0..3 = 1, 2, 4 or 8 bytes) starts a program operation of the timed length. The write is checked first. If w differs from the width field (control bits 9:8), the parallelism flag (status bit 6) is set. If the offset is not a multiple of the access size, the alignment flag (status bit 5) is set. Either fault leaves busy low.
- R10: If the fault input for write protection is high when an operation would start, the write-protection flag (status bit 4) is set and busy stays low.
- R11: If the operation fault input is high when an operation starts, the operation flag (status bit 1) is set in the same cycle that busy falls.
- R12: Status flags are sticky. Writing 1 to a flag bit at offset 0x0C clears only that flag, and writing 0 leaves it unchanged.
- R13: A flash-port write is ignored when program enable is clear: busy stays low and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fl_wr | input | 1 | Flash-space write strobe |
| fl_off | input | 3 | Byte offset of the flash write within a doubleword |
| fl_size | input | 2 | Width code of the flash write |
| inj_wrprot | input | 1 | Injects a write-protection fault at operation start |
| inj_operr | input | 1 | Injects an operation fault reported at completion |
| op_busy | output | 1 | Operation in progress |

## Verification
The bench targets the lock state machine where it is easiest to get wrong. It writes a key while the unit is already open, gives a wrong first key, and gives a wrong second key, then tries a correct sequence each time. A design that only restarts its key sequence instead of locking for good would let that later correct sequence unlock it. The bench also walks a table of start words, covering one erase bit, none, two, and program enable mixed in. A decoder that checks only "any bit set" would start busy where the sequence flag belongs. It counts busy cycles exactly, with a zero duration included, which catches off-by-one timers. It sets two flags at once and clears one, which exposes a clear that wipes the whole status word.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    localparam int REG_AW = 5;
    localparam int SNB_W  = 4;
    localparam int NERR   = 5;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    localparam logic [REG_AW-1:0] OFS_DUR  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_KEY  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_OKEY = 5'h08;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_CTRL = 5'h10;

    // control word bit positions
    localparam int CB_PG    = 0;
    localparam int CB_SER   = 1;
    localparam int CB_MER   = 2;
    localparam int CB_SNB   = 3;
    localparam int CB_WID   = 8;
    localparam int CB_MER2  = 15;
    localparam int CB_START = 16;
    localparam int CB_LOCK  = 31;
    localparam int SB_BUSY  = 16;

    // internal error index order
    localparam int E_OP  = 0;
    localparam int E_WRP = 1;
    localparam int E_ALN = 2;
    localparam int E_PAR = 3;
    localparam int E_SEQ = 4;

    typedef enum logic [1:0] {
        KS_SHUT,
        KS_HALF,
        KS_OPEN,
        KS_DEAD
    } keyst_t;

    typedef struct packed {
        logic             mer2;
        logic [1:0]       wid;
        logic [SNB_W-1:0] snb;
        logic             mer;
        logic             ser;
        logic             pg;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.pg   = w[CB_PG];
        c.ser  = w[CB_SER];
        c.mer  = w[CB_MER];
        c.snb  = w[CB_SNB +: SNB_W];
        c.wid  = w[CB_WID +: 2];
        c.mer2 = w[CB_MER2];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c, input logic lock);
        logic [31:0] w;
        w = '0;
        w[CB_PG]            = c.pg;
        w[CB_SER]           = c.ser;
        w[CB_MER]           = c.mer;
        w[CB_SNB +: SNB_W]  = c.snb;
        w[CB_WID +: 2]      = c.wid;
        w[CB_MER2]          = c.mer2;
        w[CB_LOCK]          = lock;
        return w;
    endfunction

    function automatic logic erase_cmd_ok(input ctrl_t c);
        return ($countones({c.ser, c.mer, c.mer2}) == 1) && !c.pg;
    endfunction

    function automatic logic off_misaligned(input logic [2:0] off, input logic [1:0] sz);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return off[0];
            2'd2:    return |off[1:0];
            default: return |off;
        endcase
    endfunction

    function automatic logic [7:0] err_to_stat(input logic [NERR-1:0] e);
        logic [7:0] s;
        s = '0;
        s[1] = e[E_OP];
        s[4] = e[E_WRP];
        s[5] = e[E_ALN];
        s[6] = e[E_PAR];
        s[7] = e[E_SEQ];
        return s;
    endfunction

    function automatic logic [NERR-1:0] stat_to_err(input logic [7:0] s);
        logic [NERR-1:0] e;
        e[E_OP]  = s[1];
        e[E_WRP] = s[4];
        e[E_ALN] = s[5];
        e[E_PAR] = s[6];
        e[E_SEQ] = s[7];
        return e;
    endfunction

endpackage

// File: rtl/fcg_keyseq.sv
module fcg_keyseq
    import flashctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        relock,
    output logic        locked,
    output logic        hard_lock
);

    keyst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            case (st_q)
                KS_SHUT: st_d = (key_data == KEY_FIRST)  ? KS_HALF : KS_DEAD;
                KS_HALF: st_d = (key_data == KEY_SECOND) ? KS_OPEN : KS_DEAD;
                default: st_d = KS_DEAD;
            endcase
        end else if (relock && st_q == KS_OPEN) begin
            st_d = KS_SHUT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= KS_SHUT;
        else     st_q <= st_d;
    end

    assign locked    = (st_q != KS_OPEN);
    assign hard_lock = (st_q == KS_DEAD);

endmodule

// File: rtl/fcg_optimer.sv
module fcg_optimer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic [W-1:0] dur,
    output logic         busy,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (launch)      cnt_q <= (dur == '0) ? W'(1) : dur;
        else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == W'(1));

endmodule

// File: rtl/fcg_errflags.sv
module fcg_errflags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/flashctl_guard.sv
module flashctl_guard
    import flashctl_pkg::*;
#(
    parameter int DUR_W   = 16,
    parameter int DEF_DUR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fl_wr,
    input  logic [2:0]        fl_off,
    input  logic [1:0]        fl_size,
    input  logic              inj_wrprot,
    input  logic              inj_operr,
    output logic              op_busy
);

    localparam int PADW = 32 - DUR_W;

    logic [DUR_W-1:0] dur_q;
    ctrl_t            ctrl_q, ctrl_new;
    logic             operr_pend_q;
    logic             locked, hard_lock;
    logic             tmr_done;
    logic [NERR-1:0]  err_q, err_set, err_clr;

    logic wr_key, wr_ctrl, wr_stat, wr_dur;
    logic relock, ctrl_load, start_req, start_ok;
    logic prog_try, par_bad, aln_bad, prog_clean;
    logic launch;

    assign wr_key  = reg_wr && (reg_addr == OFS_KEY);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_dur  = reg_wr && (reg_addr == OFS_DUR);

    assign ctrl_new  = ctrl_from_word(reg_wdata);
    assign relock    = wr_ctrl && !locked && reg_wdata[CB_LOCK];
    assign ctrl_load = wr_ctrl && !locked && !op_busy && !reg_wdata[CB_LOCK];
    assign start_req = ctrl_load && reg_wdata[CB_START];
    assign start_ok  = start_req && erase_cmd_ok(ctrl_new);

    assign prog_try   = fl_wr && !locked && !op_busy && ctrl_q.pg;
    assign par_bad    = prog_try && (fl_size != ctrl_q.wid);
    assign aln_bad    = prog_try && off_misaligned(fl_off, fl_size);
    assign prog_clean = prog_try && !par_bad && !aln_bad;

    assign launch = (start_ok || prog_clean) && !inj_wrprot;

    fcg_keyseq u_keys (
        .clk       (clk),
        .rst       (rst),
        .key_wr    (wr_key),
        .key_data  (reg_wdata),
        .relock    (relock),
        .locked    (locked),
        .hard_lock (hard_lock)
    );

    fcg_optimer #(.W(DUR_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .dur    (dur_q),
        .busy   (op_busy),
        .done   (tmr_done)
    );

    always_comb begin
        err_set        = '0;
        err_set[E_SEQ] = start_req && !erase_cmd_ok(ctrl_new);
        err_set[E_PAR] = par_bad;
        err_set[E_ALN] = aln_bad;
        err_set[E_WRP] = (start_ok || prog_clean) && inj_wrprot;
        err_set[E_OP]  = tmr_done && operr_pend_q;
        err_clr        = wr_stat ? stat_to_err(reg_wdata[7:0]) : '0;
    end

    fcg_errflags #(.N(NERR)) u_err (
        .clk     (clk),
        .rst     (rst),
        .set_vec (err_set),
        .clr_vec (err_clr),
        .flags   (err_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q        <= DUR_W'(DEF_DUR);
            ctrl_q       <= '0;
            operr_pend_q <= 1'b0;
        end else begin
            if (wr_dur)    dur_q  <= reg_wdata[DUR_W-1:0];
            if (ctrl_load) ctrl_q <= ctrl_new;
            if (launch)        operr_pend_q <= inj_operr;
            else if (tmr_done) operr_pend_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_DUR:  reg_rdata = {{PADW{1'b0}}, dur_q};
            OFS_STAT: reg_rdata = {15'd0, op_busy, 8'd0, err_to_stat(err_q)};
            OFS_CTRL: reg_rdata = ctrl_to_word(ctrl_q, locked);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker
    import flashctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              op_busy,
    input logic              locked,
    input logic              hard_lock,
    input ctrl_t             ctrl_bits,
    input logic [NERR-1:0]   err_bits
);

    logic            ctrl_w;
    logic [NERR-1:0] clr_m;

    assign ctrl_w = reg_wr && (reg_addr == OFS_CTRL);
    assign clr_m  = (reg_wr && reg_addr == OFS_STAT) ? stat_to_err(reg_wdata[7:0]) : '0;

    p_dead_stays_r3: assert property (@(posedge clk) disable iff (rst)
        hard_lock |=> (hard_lock && locked));

    p_locked_ctrl_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && ctrl_w) |=> $stable(ctrl_bits));

    p_relock_r5: assert property (@(posedge clk) disable iff (rst)
        (!locked && ctrl_w && reg_wdata[CB_LOCK]) |=> locked);

    p_start_open_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(op_busy) |-> !$past(locked));

    p_seq_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_bits[E_SEQ]) |-> !op_busy);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (op_busy && ctrl_w) |=> $stable(ctrl_bits));

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (|(err_bits & ~clr_m)) |=>
            ((err_bits & $past(err_bits & ~clr_m)) == $past(err_bits & ~clr_m)));

endmodule

bind flashctl_guard fcg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .op_busy   (op_busy),
    .locked    (locked),
    .hard_lock (hard_lock),
    .ctrl_bits (ctrl_q),
    .err_bits  (err_q)
);

// File: tb/sim_flashctl_guard.sv
module sim_flashctl_guard;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_DUR  = 5'h00;
    localparam logic [4:0] A_KEY  = 5'h04;
    localparam logic [4:0] A_STAT = 5'h0C;
    localparam logic [4:0] A_CTRL = 5'h10;
    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;

    // {start word, expect sequence flag, expect busy}
    localparam logic [33:0] VEC [7] = '{
        {32'h0001_0002, 1'b0, 1'b1},
        {32'h0001_0004, 1'b0, 1'b1},
        {32'h0001_8000, 1'b0, 1'b1},
        {32'h0001_0000, 1'b1, 1'b0},
        {32'h0001_0006, 1'b1, 1'b0},
        {32'h0001_0003, 1'b1, 1'b0},
        {32'h0001_002A, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_wr = 1'b0;
    logic [2:0]  fl_off = '0;
    logic [1:0]  fl_size = '0;
    logic        inj_wrprot = 1'b0;
    logic        inj_operr = 1'b0;
    logic        op_busy;

    int n_chk  = 0;
    int n_fail = 0;

    flashctl_guard #(.DUR_W(16), .DEF_DUR(8)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_wr(fl_wr),
        .fl_off(fl_off), .fl_size(fl_size), .inj_wrprot(inj_wrprot),
        .inj_operr(inj_operr), .op_busy(op_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic flw(input logic [2:0] off, input logic [1:0] sz);
        @(negedge clk);
        fl_wr = 1'b1; fl_off = off; fl_size = sz;
        @(negedge clk);
        fl_wr = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        #1;
        while (op_busy && n < 100000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int n;
        do_reset();

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h8000_0000);
        rd(A_STAT, v); chk("R1 stat", v, 32'h0);
        rd(A_DUR, v);  chk("R1 dur", v, 32'd8);

        // R4 locked writes ignored
        wr(A_CTRL, 32'h0001_0002);
        chk("R4 no busy", {31'b0, op_busy}, 32'h0);
        rd(A_CTRL, v); chk("R4 ctrl", v, 32'h8000_0000);

        // R2 unlock
        wr(A_KEY, K1);
        rd(A_CTRL, v); chk("R2 half", v, 32'h8000_0000);
        wr(A_KEY, K2);
        rd(A_CTRL, v); chk("R2 open", v, 32'h0);

        // R6/R7 start decoding table
        wr(A_DUR, 32'd5);
        for (int i = 0; i < 7; i++) begin
            wr(A_CTRL, VEC[i][33:2]);
            count_busy(n);
            chk("R6 busy", {31'b0, n != 0}, {31'b0, VEC[i][0]});
            if (VEC[i][0]) chk("R6 length", n, 32'd5);
            rd(A_STAT, v);
            chk("R7 seq flag", {31'b0, v[7]}, {31'b0, VEC[i][1]});
            wr(A_STAT, 32'hFF);
        end
        rd(A_CTRL, v); chk("R6 sector readback", v, 32'h0000_002A);

        // R6 zero duration treated as one
        wr(A_DUR, 32'd0);
        wr(A_CTRL, 32'h0001_0004);
        count_busy(n); chk("R6 zero dur", n, 32'd1);

        // R8 ignore while busy, R5 relock while busy
        wr(A_DUR, 32'd10);
        wr(A_CTRL, 32'h0001_0002);
        wr(A_CTRL, 32'h0001_0004);
        rd(A_CTRL, v); chk("R8 ctrl held", v, 32'h0000_0002);
        rd(A_STAT, v); chk("R8 no seq", v & 32'hFF, 32'h0);
        wr(A_CTRL, 32'h8000_0000);
        chk("R8 still busy", {31'b0, op_busy}, 32'h1);
        rd(A_CTRL, v); chk("R5 relock", v, 32'h8000_0002);
        count_busy(n);
        wr(A_CTRL, 32'h0000_0001);
        rd(A_CTRL, v); chk("R5 locked after", v, 32'h8000_0002);
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CTRL, v); chk("R5 reopen", v, 32'h0000_0002);

        // R9 program
        wr(A_DUR, 32'd6);
        wr(A_CTRL, 32'h0000_0201);
        flw(3'd4, 2'd2);
        count_busy(n); chk("R9 program length", n, 32'd6);
        flw(3'd1, 2'd1);
        chk("R9 no busy", {31'b0, op_busy}, 32'h0);
        rd(A_STAT, v); chk("R9 par+aln", v, 32'h0000_0060);
        // R12 selective clear
        wr(A_STAT, 32'h40);
        rd(A_STAT, v); chk("R12 partial clear", v, 32'h20);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R12 zero keeps", v, 32'h20);
        wr(A_STAT, 32'h20);
        flw(3'd2, 2'd2);
        rd(A_STAT, v); chk("R9 aln only", v, 32'h20);
        wr(A_STAT, 32'hFF);

        // R13 pg clear
        wr(A_CTRL, 32'h0000_0002);
        flw(3'd0, 2'd2);
        chk("R13 no busy", {31'b0, op_busy}, 32'h0);
        rd(A_STAT, v); chk("R13 no flag", v, 32'h0);

        // R10 write protect
        inj_wrprot = 1'b1;
        wr(A_CTRL, 32'h0001_0002);
        inj_wrprot = 1'b0;
        chk("R10 no busy", {31'b0, op_busy}, 32'h0);
        rd(A_STAT, v); chk("R10 flag", v, 32'h10);
        wr(A_STAT, 32'h10);

        // R11 operation fault
        inj_operr = 1'b1;
        wr(A_CTRL, 32'h0001_0004);
        inj_operr = 1'b0;
        rd(A_STAT, v); chk("R11 not yet", v & 32'hFF, 32'h0);
        count_busy(n);
        rd(A_STAT, v); chk("R11 flag", v, 32'h02);
        wr(A_STAT, 32'h02);

        // R3 key while open
        wr(A_KEY, K1);
        rd(A_CTRL, v); chk("R3 key while open", v[31], 1'b1);
        wr(A_KEY, K1); wr(A_KEY, K2);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R3 stays locked", v, 32'h8000_0004);

        // R3 wrong first key
        do_reset();
        wr(A_KEY, 32'h1111_1111);
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CTRL, v); chk("R3 bad first", v, 32'h8000_0000);

        // R3 wrong second key
        do_reset();
        wr(A_KEY, K1); wr(A_KEY, 32'hCDEF_89AA);
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CTRL, v); chk("R3 bad second", v, 32'h8000_0000);

        // R1/R2 reset clears hard lock
        do_reset();
        wr(A_KEY, K1); wr(A_KEY, K2);
        rd(A_CTRL, v); chk("R2 after reset", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule